// File: doc/BRIEF.md
# Flash Block Erase Command Sequencer

This block erases one or more blocks of a parallel NOR-style flash device from the host side. Block addresses arrive on a valid/ready request stream, each with a flag that marks the final block of a sequence. The block turns each request into command writes and status reads on a plain flash bus, made of an address bus, separate data-out and data-in buses with an output-enable, and active-low chip-enable, write-strobe and read-strobe pins. When the sequence ends, the device is put back into array-read mode and a one-cycle completion pulse is raised, together with the last status byte read and an error flag.

There are two flows. In the queued flow the block issues a queue-setup command to each block and reads the extended status. It repeats the setup while the device reports no queue space. Once space is free it confirms the erase and moves on to the next request, so several blocks can be accepted before the device finishes. It then polls the main status once, after the last block. In the single-block flow every block gets a plain erase setup and a confirm, and the block waits for the device to report ready before it accepts the next request. If queue space does not appear within a set number of cycles, the sequence is aborted.

Back-pressure on the request stream: a request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle, or between the blocks of a queued sequence, or between the blocks of a single-block sequence once the device reports ready. While `req_ready` is low, the requester must hold `req_valid`, `req_blk` and `req_last` unchanged.

Top module: `flash_erase_seq`

## Requirements
- R1: In queued mode (`queued_mode`=1, sampled when the first block of a sequence is accepted) every block starts with a write of data 0x28 to the block address, followed by a read of the extended status.
- R2: While extended status bit 7 reads 0, the block repeats the 0x28 write and the status read. The first time bit 7 reads 1, the next bus write is data 0xD0 to the same block address.
- R3: `req_ready` is high only while no bus cycle is running and the sequencer is idle or waiting for the next block. A request held valid while `req_ready` is low is taken exactly once.
- R4: In single-block mode (`queued_mode`=0) each block gets data 0x20 then 0xD0 at its address. The main status is then read until bit 7 is 1, before any write for the next block.
- R5: In queued mode, after the confirm of the block flagged last, the main status is read until bit 7 is 1 before the sequence ends.
- R6: A sequence ends with a write of data 0xFF to the last block address. `done` is then high for exactly one cycle, with `fin_status` equal to the last status byte read.
- R7: If extended status bit 7 is still 0 at least TIMEOUT cycles after the block was accepted, no 0xD0 is written, 0xFF is written, and `done` comes with `err`=1. A later sequence that completes reports `err`=0.
- R8: In a write cycle `fl_ce_n` and `fl_we_n` are low together for exactly WE_CYC cycles. `fl_addr` and `fl_dq_out` hold the same value in the cycle before the strobe falls and in the cycle after it rises.
- R9: In a read cycle `fl_ce_n` and `fl_oe_n` are low for exactly RD_CYC cycles. `fl_dq_oe` is 0 whenever `fl_oe_n` is low, and `fl_we_n` and `fl_oe_n` are never low together.
- R10: After reset `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dq_oe` is 0, `req_ready` is 1, and `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| queued_mode | input | 1 | 1 selects the queued flow, 0 selects the single-block flow |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_blk | input | ADDR_W | Block address of the request |
| req_last | input | 1 | Marks the final block of a sequence |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Queue time-out abort, valid with `done` |
| fin_status | output | 8 | Last status byte read |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Enable for the write-data driver |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |

## Verification
The bench builds the block with an 8-bit address, WE_CYC=3, RD_CYC=2 and TIMEOUT=60. With these values a time-out abort takes only a few dozen cycles, so the bench can measure it against its bounds. The strobe widths also differ between reads and writes, so a mix-up of the two lengths shows up. A bench model of the device can hold queue space away for a chosen number of reads and report busy for a chosen number of polls. This puts retry loops, single-block pacing and a late ready flag within reach of the scoreboard of bus writes.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] CMD_QSETUP  = 8'h28;
  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam int         READY_BIT   = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_XSR, S_CONF, S_NEXT, S_POLL, S_RESET
  } seq_state_t;

  typedef enum logic [1:0] {
    P_IDLE, P_LEAD, P_STROBE, P_TRAIL
  } bus_phase_t;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WE_CYC = 3,
  parameter int RD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              busy,
  output logic              cyc_done,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int MAXC  = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  bus_phase_t       phase;
  logic             is_rd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;

  assign len  = is_rd ? CNT_W'(RD_CYC) : CNT_W'(WE_CYC);
  assign busy = (phase != P_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      is_rd     <= 1'b0;
      cnt       <= '0;
      cyc_done  <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
    end else begin
      cyc_done <= 1'b0;
      case (phase)
        P_IDLE: if (go) begin
          fl_addr   <= addr_i;
          fl_dq_out <= data_i;
          fl_dq_oe  <= !rd;
          is_rd     <= rd;
          phase     <= P_LEAD;
        end
        P_LEAD: begin
          fl_ce_n <= 1'b0;
          fl_we_n <= is_rd;
          fl_oe_n <= !is_rd;
          cnt     <= '0;
          phase   <= P_STROBE;
        end
        P_STROBE: begin
          cnt <= cnt + 1'b1;
          if (cnt == len - 1'b1) begin
            if (is_rd) rdata <= fl_dq_in;
            fl_ce_n <= 1'b1;
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            phase   <= P_TRAIL;
          end
        end
        default: begin
          fl_dq_oe <= 1'b0;
          cyc_done <= 1'b1;
          phase    <= P_IDLE;
        end
      endcase
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  assert_ce_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
  assert_setup_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));
endmodule

// File: rtl/flash_erase_tmo.sv
module flash_erase_tmo #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1) + 1;
  logic [CW-1:0] cnt;

  assign expired = (cnt >= CW'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  assert_tmo_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expired) && !$past(clr)) |-> expired);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int WE_CYC  = 3,
  parameter int RD_CYC  = 2,
  parameter int TIMEOUT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queued_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_blk,
  input  logic              req_last,
  output logic              done,
  output logic              err,
  output logic [7:0]        fin_status,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  seq_state_t        state;
  logic              launch, queued_q, last_q;
  logic [ADDR_W-1:0] blk_q;
  logic              bus_busy, bus_done, bus_rd, tmo_exp, take;
  logic [7:0]        bus_rdata, bus_wdata;

  assign req_ready = (state == S_IDLE) || (state == S_NEXT);
  assign take      = req_valid && req_ready;
  assign bus_rd    = (state == S_XSR) || (state == S_POLL);

  always_comb begin
    case (state)
      S_SETUP: bus_wdata = queued_q ? CMD_QSETUP : CMD_SETUP;
      S_CONF:  bus_wdata = CMD_CONFIRM;
      default: bus_wdata = CMD_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      launch     <= 1'b0;
      queued_q   <= 1'b0;
      last_q     <= 1'b0;
      blk_q      <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      fin_status <= '0;
    end else begin
      launch <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE, S_NEXT: if (take) begin
          blk_q  <= req_blk;
          last_q <= req_last;
          if (state == S_IDLE) begin
            queued_q <= queued_mode;
            err      <= 1'b0;
          end
          state  <= S_SETUP;
          launch <= 1'b1;
        end
        S_SETUP: if (bus_done) begin
          state  <= queued_q ? S_XSR : S_CONF;
          launch <= 1'b1;
        end
        S_XSR: if (bus_done) begin
          fin_status <= bus_rdata;
          launch     <= 1'b1;
          if (bus_rdata[READY_BIT]) state <= S_CONF;
          else if (tmo_exp) begin
            err   <= 1'b1;
            state <= S_RESET;
          end else state <= S_SETUP;
        end
        S_CONF: if (bus_done) begin
          if (queued_q && !last_q) state <= S_NEXT;
          else begin
            state  <= S_POLL;
            launch <= 1'b1;
          end
        end
        S_POLL: if (bus_done) begin
          fin_status <= bus_rdata;
          if (!bus_rdata[READY_BIT]) launch <= 1'b1;
          else if (!queued_q && !last_q) state <= S_NEXT;
          else begin
            state  <= S_RESET;
            launch <= 1'b1;
          end
        end
        default: if (bus_done) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  flash_erase_tmo #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(take),
    .run((state == S_SETUP) || (state == S_XSR)), .expired(tmo_exp)
  );

  flash_bus_cycle #(.ADDR_W(ADDR_W), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(launch), .rd(bus_rd), .addr_i(blk_q),
    .data_i(bus_wdata), .busy(bus_busy), .cyc_done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  assert_ready_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_busy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_confirm_needs_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XSR && bus_done && !bus_rdata[READY_BIT]) |=> (state != S_CONF));
  assert_abort_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XSR && bus_done && !bus_rdata[READY_BIT] && tmo_exp) |=> err);
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int AW = 8, WE = 3, RD = 2, TMO = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic queued_mode = 1'b0, req_valid = 1'b0, req_last = 1'b0;
  logic [AW-1:0] req_blk = '0;
  logic req_ready, done, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [7:0] fin_status, fl_dq_out, fl_dq_in;
  logic [AW-1:0] fl_addr;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] expq[$];
  logic [15:0] prev_got = '0;
  bit allow_dup = 0, seen28 = 0;
  int t_first28 = 0, t_ff = 0, we_low = 0, oe_low = 0, bus_bad = 0;

  logic [7:0] mcmd = 8'hFF;
  int xsr_wait = 0, sr_wait = 0, sr_busy = 0, pidx = 0, viol = 0;
  int xsr_plan[8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_erase_seq #(.ADDR_W(AW), .WE_CYC(WE), .RD_CYC(RD), .TIMEOUT(TMO)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .queued_mode(queued_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_blk(req_blk), .req_last(req_last), .done(done),
    .err(err), .fin_status(fin_status), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device model
  assign fl_dq_in = (mcmd == 8'h28) ? {xsr_wait == 0, 7'h00} : {sr_wait == 0, 7'h05};

  always @(posedge fl_we_n) if (rst_n) begin
    if (fl_dq_out == 8'h20 && sr_wait != 0) viol++;
    if (fl_dq_out == 8'h28 && mcmd != 8'h28) xsr_wait = xsr_plan[pidx];
    if (fl_dq_out == 8'hD0) begin sr_wait = sr_busy; pidx++; end
    mcmd = fl_dq_out;
  end

  always @(posedge fl_oe_n) if (rst_n) begin
    if (mcmd == 8'h28) begin if (xsr_wait > 0) xsr_wait--; end
    else if (sr_wait > 0) sr_wait--;
  end

  // monitor: scoreboard of bus writes (R1 R2 R4 R6)
  always @(posedge fl_we_n) if (rst_n) begin
    logic [15:0] got;
    got = {fl_addr, fl_dq_out};
    chk(we_low == WE, "R8 write strobe width", we_low, WE);
    if (fl_dq_out == 8'h28 && !seen28) begin seen28 = 1; t_first28 = cyc; end
    if (fl_dq_out == 8'hFF) t_ff = cyc;
    if (allow_dup && got == prev_got) begin
      // repeated queue setup during a time-out wait
    end else if (expq.size() == 0) begin
      chk(0, "R1/R2/R4/R6 unexpected write", got, 0);
    end else begin
      logic [15:0] e;
      e = expq.pop_front();
      chk(got == e, "R1/R2/R4/R6 write sequence", got, e);
    end
    prev_got = got;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n && fl_ce_n) bus_bad++;
      if (!fl_oe_n && (fl_ce_n || fl_dq_oe || !fl_we_n)) bus_bad++;
    end
    we_low <= !fl_we_n ? we_low + 1 : 0;
    if (!fl_oe_n) oe_low <= oe_low + 1;
    else if (oe_low != 0) begin
      chk(oe_low == RD, "R9 read strobe width", oe_low, RD);
      oe_low <= 0;
    end
  end

  // driver: pushes expected writes, feeds requests, checks the end
  task automatic run_seq(input bit qm, input int n, input logic [7:0] base,
                         input bit exp_err, output int stall);
    logic [7:0] a;
    stall = 0;
    seen28 = 0; pidx = 0; viol = 0; allow_dup = exp_err;
    for (int i = 0; i < n; i++) begin
      a = base + 8'(i * 16);
      if (qm) begin
        if (exp_err) expq.push_back({a, 8'h28});
        else begin
          for (int k = 0; k <= xsr_plan[i]; k++) expq.push_back({a, 8'h28});
          expq.push_back({a, 8'hD0});
        end
      end else begin
        expq.push_back({a, 8'h20});
        expq.push_back({a, 8'hD0});
      end
    end
    expq.push_back({a, 8'hFF});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      queued_mode = qm; req_valid = 1; req_blk = base + 8'(i * 16); req_last = (i == n - 1);
      while (!req_ready) begin stall++; @(negedge clk); end
      @(posedge clk);
    end
    @(negedge clk); req_valid = 0; req_last = 0;
    while (!done) @(negedge clk);
    chk(err == exp_err, "R6/R7 err flag", err, exp_err);
    chk(fin_status == (exp_err ? 8'h00 : 8'h85), "R6 final status", fin_status,
        exp_err ? 8'h00 : 8'h85);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
    chk(expq.size() == 0, "R1/R2/R4/R6 writes missing", expq.size(), 0);
    chk(viol == 0, "R4 next setup before ready", viol, 0);
    chk(sr_wait == 0 || exp_err, "R5 ended before device ready", sr_wait, 0);
    expq.delete();
  endtask

  initial begin
    int stall;
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R10 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    chk(!fl_dq_oe && req_ready && !done && !err, "R10 status idle",
        {fl_dq_oe, req_ready, done, err}, 4'b0100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R5: queued, three blocks, block 1 waits twice for space
    xsr_plan[0] = 0; xsr_plan[1] = 2; xsr_plan[2] = 0; sr_busy = 3;
    run_seq(1, 3, 8'h10, 0, stall);
    chk(stall > 0, "R3 back-pressure seen", stall, 1);

    // R4: single-block mode, device busy for four polls per block
    sr_busy = 4;
    run_seq(0, 2, 8'h21, 0, stall);
    chk(stall > 0, "R4 waits between blocks", stall, 1);

    // R7: queue never frees
    xsr_plan[0] = 1000;
    run_seq(1, 1, 8'h40, 1, stall);
    chk(t_ff - t_first28 >= TMO && t_ff - t_first28 <= TMO + 40,
        "R7 time-out window", t_ff - t_first28, TMO);
    xsr_wait = 0;

    // R7 R6: recovery with a single queued block, slow device
    xsr_plan[0] = 1; sr_busy = 6;
    run_seq(1, 1, 8'h77, 0, stall);

    chk(bus_bad == 0, "R8/R9 strobe relations", bus_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule